// File: doc/BRIEF.md
# Masked Interrupt Router

This block collects a set of level-sensitive interrupt sources and steers each one onto an output pin that belongs to one of several processor contexts. Every source carries a pending flag that follows its input line, an enable flag, and a routing entry naming a destination context and a pin within that context. Software changes the enable flags through two write-one mask registers, one that turns sources on and one that turns them off. It programs each source's routing through a register of its own.

Each context also owns a local compare interrupt. An external compare event sets it. A write to the context's compare value register clears it. It has its own routing entry naming a pin of that context. Every output pin is the OR of all pending, enabled sources routed to it, together with any compare interrupt routed to it. The pins are recomputed from the stored state on every cycle. A mask change therefore drops a pin whose only cause was masked, and it raises a pin for a source that was already pending when it was unmasked.

The register port is a single-cycle write strobe with address and data, and a combinational read path. The output pins are registered. They reflect any change of state one clock edge after that state changes.

Top module: `irq_router`

## Requirements
- R1: A write to set-mask word w (address 0x00 + w) enables every source w*32+i whose data bit i is 1. Sources whose data bit is 0 keep their enable.
- R2: A write to clear-mask word w (address 0x08 + w) disables every source w*32+i whose data bit i is 1. Sources whose data bit is 0 keep their enable.
- R3: A source's pending flag is its input level, sampled each clock, whether or not the source is enabled. A pending source that is later enabled raises its pin on the edge after the enable takes effect.
- R4: Output pin irq_pins[c*8+p] is high exactly when, in the state of the previous cycle, some source is pending, enabled, has route-enable set, and routes to context c and pin p, or when context c's compare interrupt is pending and routed to pin p.
- R5: Disabling the only active source on a pin lowers that pin on the edge after the clear-mask write takes effect.
- R6: A source whose routing names a context index of NUM_CTX or more drives no pin.
- R7: Source routing register (address 0x40 + s) has route-enable in bit 31, context index in bits 6:4, and pin index in bits 2:0. A source with route-enable 0 drives no pin.
- R8: A high cmp_hit[c] sets context c's compare-pending flag. The flag drives pin p of context c only while the compare routing register (address 0x10 + c; enable bit 31, pin bits 2:0) has its enable set.
- R9: A write to context c's compare value register (address 0x18 + c) clears its compare-pending flag unless cmp_hit[c] is high in the same cycle. The routed pin falls on the following edge.
- R10: Reading a set-mask or clear-mask address returns that word's current enable bits. Reading a routing address returns the stored fields in their write positions, with all other bits zero.
- R11: Reset clears all enables, pending flags, routing entries and output pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_level | input | NUM_SRC | Level of each interrupt source |
| cmp_hit | input | NUM_CTX | Compare event per context; sets compare-pending |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| irq_pins | output | NUM_CTX*8 | Output pins, index context*8 + pin |

## Verification
The bound checker watches a fixed set of relations on every clock. A set-mask write leaves all its one-bits enabled on the next cycle. A clear-mask write leaves all its one-bits disabled. A compare value write without a concurrent hit clears that context's compare flag. A raised pin always had an enabled pending cause one cycle before. With nothing enabled and no compare pending, all pins are low. The exact per-pin routing falls to the bench's reference model, compared against every pin on every cycle: the OR of several sources, out-of-range contexts, route-enable, and read-back. So do the directed orderings, such as unmasking an already pending source or masking the last active one.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    parameter int REG_W     = 32;
    parameter int CTX_IDX_W = 3;
    parameter int PIN_IDX_W = 3;
    parameter int NUM_PIN   = 1 << PIN_IDX_W;
    parameter int ADDR_DEF  = 8;

    // register address bases
    parameter int SET_BASE  = 'h00;
    parameter int CLR_BASE  = 'h08;
    parameter int CRT_BASE  = 'h10;
    parameter int CVAL_BASE = 'h18;
    parameter int SRT_BASE  = 'h40;

    typedef struct packed {
        logic                 en;
        logic [CTX_IDX_W-1:0] ctx;
        logic [PIN_IDX_W-1:0] pin;
    } route_t;

    function automatic route_t route_unpack(input logic [REG_W-1:0] d);
        route_t r;
        r.en  = d[REG_W-1];
        r.ctx = d[4 +: CTX_IDX_W];
        r.pin = d[0 +: PIN_IDX_W];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] route_pack(input route_t r);
        logic [REG_W-1:0] d;
        d = '0;
        d[REG_W-1]       = r.en;
        d[4 +: CTX_IDX_W] = r.ctx;
        d[0 +: PIN_IDX_W] = r.pin;
        return d;
    endfunction

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = ADDR_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    output logic [NUM_SRC-1:0] en_q
);
    localparam int NUM_WORDS = NUM_SRC / REG_W;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic set_sel;
        logic clr_sel;

        assign set_sel = wr_en && (wr_addr == ADDR_W'(SET_BASE + w));
        assign clr_sel = wr_en && (wr_addr == ADDR_W'(CLR_BASE + w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[w*REG_W +: REG_W] <= '0;
            end else if (set_sel) begin
                en_q[w*REG_W +: REG_W] <= en_q[w*REG_W +: REG_W] | wr_data;
            end else if (clr_sel) begin
                en_q[w*REG_W +: REG_W] <= en_q[w*REG_W +: REG_W] & ~wr_data;
            end
        end
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = ADDR_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [NUM_CTX-1:0] cmp_hit,
    output route_t             src_route [NUM_SRC],
    output route_t             cmp_route [NUM_CTX],
    output logic [NUM_CTX-1:0] cmp_pend_q
);
    route_t wr_route;
    assign wr_route = route_unpack(wr_data);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic sel;
        assign sel = wr_en && (wr_addr == ADDR_W'(SRT_BASE + s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_route[s] <= '0;
            end else if (sel) begin
                src_route[s] <= wr_route;
            end
        end
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        logic rt_sel;
        logic val_sel;
        assign rt_sel  = wr_en && (wr_addr == ADDR_W'(CRT_BASE + c));
        assign val_sel = wr_en && (wr_addr == ADDR_W'(CVAL_BASE + c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_route[c] <= '0;
            end else if (rt_sel) begin
                cmp_route[c] <= '{en: wr_route.en, ctx: CTX_IDX_W'(c), pin: wr_route.pin};
            end
        end

        // a compare event in the same cycle wins over the clearing write
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_pend_q[c] <= 1'b0;
            end else if (cmp_hit[c]) begin
                cmp_pend_q[c] <= 1'b1;
            end else if (val_sel) begin
                cmp_pend_q[c] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_pin_merge.sv
module irq_pin_merge
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CTX = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         pend_q,
    input  logic [NUM_SRC-1:0]         en_q,
    input  route_t                     src_route [NUM_SRC],
    input  route_t                     cmp_route [NUM_CTX],
    input  logic [NUM_CTX-1:0]         cmp_pend_q,
    output logic [NUM_CTX*NUM_PIN-1:0] irq_pins
);
    localparam int NUM_OUT = NUM_CTX * NUM_PIN;

    logic [NUM_OUT-1:0] pins_nxt;

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            logic [NUM_SRC-1:0] hit;
            for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
                assign hit[s] = pend_q[s] && en_q[s] && src_route[s].en &&
                                (src_route[s].ctx == CTX_IDX_W'(c)) &&
                                (src_route[s].pin == PIN_IDX_W'(p));
            end
            assign pins_nxt[c*NUM_PIN + p] = (|hit) ||
                (cmp_pend_q[c] && cmp_route[c].en &&
                 (cmp_route[c].pin == PIN_IDX_W'(p)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pins <= '0;
        end else begin
            irq_pins <= pins_nxt;
        end
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = ADDR_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_level,
    input  logic [NUM_CTX-1:0]         cmp_hit,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [REG_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [REG_W-1:0]           rd_data,
    output logic [NUM_CTX*NUM_PIN-1:0] irq_pins
);
    localparam int NUM_WORDS = NUM_SRC / REG_W;

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_CTX-1:0] cmp_pend_q;
    route_t             src_route [NUM_SRC];
    route_t             cmp_route [NUM_CTX];

    // pending follows the line level regardless of the enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= src_level;
        end
    end

    irq_mask_bank #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_q    (en_q)
    );

    irq_route_table #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .ADDR_W  (ADDR_W)
    ) route_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cmp_hit    (cmp_hit),
        .src_route  (src_route),
        .cmp_route  (cmp_route),
        .cmp_pend_q (cmp_pend_q)
    );

    irq_pin_merge #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX)
    ) merge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_q     (pend_q),
        .en_q       (en_q),
        .src_route  (src_route),
        .cmp_route  (cmp_route),
        .cmp_pend_q (cmp_pend_q),
        .irq_pins   (irq_pins)
    );

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_addr == ADDR_W'(SET_BASE + w) || rd_addr == ADDR_W'(CLR_BASE + w)) begin
                rd_data = en_q[w*REG_W +: REG_W];
            end
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            if (rd_addr == ADDR_W'(SRT_BASE + s)) begin
                rd_data = route_pack(src_route[s]);
            end
        end
        for (int c = 0; c < NUM_CTX; c++) begin
            if (rd_addr == ADDR_W'(CRT_BASE + c)) begin
                rd_data = route_pack('{en: cmp_route[c].en, ctx: '0, pin: cmp_route[c].pin});
            end
        end
    end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = ADDR_DEF
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [REG_W-1:0]           wr_data,
    input logic [NUM_CTX-1:0]         cmp_hit,
    input logic [NUM_CTX*NUM_PIN-1:0] irq_pins,
    input logic [NUM_SRC-1:0]         en_q,
    input logic [NUM_SRC-1:0]         pend_q,
    input logic [NUM_CTX-1:0]         cmp_pend_q
);
    localparam int NUM_WORDS = NUM_SRC / REG_W;

    logic [NUM_SRC-1:0] set_full;
    logic [NUM_SRC-1:0] clr_full;

    always_comb begin
        set_full = '0;
        clr_full = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (wr_en && wr_addr == ADDR_W'(SET_BASE + w)) set_full[w*REG_W +: REG_W] = wr_data;
            if (wr_en && wr_addr == ADDR_W'(CLR_BASE + w)) clr_full[w*REG_W +: REG_W] = wr_data;
        end
    end

    p_set_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_full) |=> ((en_q & $past(set_full)) == $past(set_full)));

    p_clr_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_full) |=> ((en_q & $past(clr_full)) == '0));

    p_pin_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_pins) |-> $past((|(pend_q & en_q)) || (|cmp_pend_q)));

    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0 && cmp_pend_q == '0) |=> (irq_pins == '0));

    p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_pins == '0));

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        p_cmp_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(CVAL_BASE + c) && !cmp_hit[c]) |=> !cmp_pend_q[c]);
    end

endmodule

bind irq_router irq_router_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cmp_hit    (cmp_hit),
    .irq_pins   (irq_pins),
    .en_q       (en_q),
    .pend_q     (pend_q),
    .cmp_pend_q (cmp_pend_q)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;
    localparam int NCTX = 4;
    localparam int NPIN = 8;
    localparam int AW   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_level = '0;
    logic [NCTX-1:0]   cmp_hit = '0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [AW-1:0]     rd_addr = '0;
    logic [31:0]       rd_data;
    logic [NCTX*NPIN-1:0] irq_pins;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_level (src_level),
        .cmp_hit   (cmp_hit),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq_pins  (irq_pins)
    );

    // ---------------- behavioural reference model ----------------
    bit m_en   [NSRC];
    bit m_pend [NSRC];
    bit m_ren  [NSRC];
    int m_rctx [NSRC];
    int m_rpin [NSRC];
    bit m_cp   [NCTX];
    bit m_cen  [NCTX];
    int m_cpin [NCTX];
    logic [NCTX*NPIN-1:0] exp_pins = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSRC; s++) begin
                m_en[s] = 0; m_pend[s] = 0; m_ren[s] = 0; m_rctx[s] = 0; m_rpin[s] = 0;
            end
            for (int c = 0; c < NCTX; c++) begin
                m_cp[c] = 0; m_cen[c] = 0; m_cpin[c] = 0;
            end
            exp_pins = '0;
        end else begin
            logic [NCTX*NPIN-1:0] e;
            int a;
            e = '0;
            for (int s = 0; s < NSRC; s++)
                if (m_pend[s] && m_en[s] && m_ren[s] && m_rctx[s] < NCTX)
                    e[m_rctx[s]*NPIN + m_rpin[s]] = 1'b1;
            for (int c = 0; c < NCTX; c++)
                if (m_cp[c] && m_cen[c]) e[c*NPIN + m_cpin[c]] = 1'b1;
            exp_pins = e;
            for (int s = 0; s < NSRC; s++) m_pend[s] = src_level[s];
            a = int'(wr_addr);
            if (wr_en) begin
                if (a < NSRC/32) begin
                    for (int i = 0; i < 32; i++) if (wr_data[i]) m_en[a*32+i] = 1;
                end else if (a >= 'h08 && a < 'h08 + NSRC/32) begin
                    for (int i = 0; i < 32; i++) if (wr_data[i]) m_en[(a-'h08)*32+i] = 0;
                end else if (a >= 'h10 && a < 'h10 + NCTX) begin
                    m_cen[a-'h10] = wr_data[31];
                    m_cpin[a-'h10] = int'(wr_data[2:0]);
                end else if (a >= 'h18 && a < 'h18 + NCTX) begin
                    m_cp[a-'h18] = 0;
                end else if (a >= 'h40 && a < 'h40 + NSRC) begin
                    m_ren[a-'h40]  = wr_data[31];
                    m_rctx[a-'h40] = int'(wr_data[6:4]);
                    m_rpin[a-'h40] = int'(wr_data[2:0]);
                end
            end
            for (int c = 0; c < NCTX; c++) if (cmp_hit[c]) m_cp[c] = 1;
        end
    end

    // every-cycle comparison of all pins against the model (R4)
    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (irq_pins !== exp_pins) begin
                n_errors++;
                $display("FAIL R4 cycle compare: irq_pins=%h expected=%h at %0t", irq_pins, exp_pins, $time);
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_cmp(input int c);
        cmp_hit[c] = 1'b1;
        @(negedge clk);
        cmp_hit[c] = 1'b0;
    endtask

    task automatic chk_pin(input string tag, input int c, input int p, input logic e);
        n_checks++;
        if (irq_pins[c*NPIN+p] !== e) begin
            n_errors++;
            $display("FAIL %s pin ctx%0d/%0d: actual=%b expected=%b", tag, c, p, irq_pins[c*NPIN+p], e);
        end
    endtask

    task automatic chk_all(input string tag, input logic [NCTX*NPIN-1:0] e);
        n_checks++;
        if (irq_pins !== e) begin
            n_errors++;
            $display("FAIL %s pins: actual=%h expected=%h", tag, irq_pins, e);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [AW-1:0] a, input logic [31:0] e);
        rd_addr = a;
        #1;
        n_checks++;
        if (rd_data !== e) begin
            n_errors++;
            $display("FAIL %s read @%h: actual=%h expected=%h", tag, a, rd_data, e);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // ---------------- directed and random stimulus ----------------
    initial begin
        step(3);
        chk_all("R11 reset", '0);
        chk_rd("R11 reset enables", 8'h00, 32'h0);
        rst_n = 1'b1;
        step(1);

        // source 5 -> ctx1 pin2, pending while disabled
        reg_wr(8'h45, 32'h8000_0012);
        src_level[5] = 1'b1;
        step(3);
        chk_pin("R3 disabled pending", 1, 2, 1'b0);
        reg_wr(8'h00, 32'h0000_0020);
        chk_rd("R1 set bit5", 8'h00, 32'h0000_0020);
        step(1);
        chk_pin("R3 unmask delivers", 1, 2, 1'b1);

        // second source on same pin
        reg_wr(8'h49, 32'h8000_0012);
        src_level[9] = 1'b1;
        reg_wr(8'h00, 32'h0000_0200);
        chk_rd("R1 others keep", 8'h00, 32'h0000_0220);
        step(1);
        reg_wr(8'h08, 32'h0000_0020);
        chk_rd("R2 clear bit5", 8'h08, 32'h0000_0200);
        step(1);
        chk_pin("R4 OR of two sources", 1, 2, 1'b1);
        reg_wr(8'h08, 32'h0000_0200);
        step(1);
        chk_pin("R5 mask last active", 1, 2, 1'b0);

        // source 40 routed out of range
        reg_wr(8'h68, 32'h8000_0050);
        src_level[40] = 1'b1;
        reg_wr(8'h01, 32'h0000_0100);
        chk_rd("R10 word1 enables", 8'h01, 32'h0000_0100);
        step(2);
        chk_all("R6 ctx out of range", '0);

        // route-enable off, then on
        reg_wr(8'h68, 32'h0000_0003);
        step(2);
        chk_all("R7 route disabled", '0);
        reg_wr(8'h68, 32'h8000_0003);
        chk_rd("R10 route readback", 8'h68, 32'h8000_0003);
        step(1);
        chk_pin("R7 route enabled", 0, 3, 1'b1);

        // pending follows the level
        src_level[40] = 1'b0;
        step(2);
        chk_pin("R3 level drop", 0, 3, 1'b0);

        // compare interrupt
        reg_wr(8'h12, 32'h8000_0007);
        pulse_cmp(2);
        step(1);
        chk_pin("R8 compare routed", 2, 7, 1'b1);
        reg_wr(8'h1A, 32'd123);
        step(1);
        chk_pin("R9 compare cleared", 2, 7, 1'b0);
        reg_wr(8'h12, 32'h0000_0007);
        pulse_cmp(2);
        step(1);
        chk_pin("R8 compare route off", 2, 7, 1'b0);
        reg_wr(8'h12, 32'h8000_0005);
        step(1);
        chk_pin("R8 compare re-routed", 2, 5, 1'b1);
        reg_wr(8'h1A, 32'd0);
        step(1);

        // random traffic, checked every cycle against the model
        for (int k = 0; k < 600; k++) begin
            src_level = {$urandom, $urandom};
            cmp_hit = (($urandom % 8) == 0) ? NCTX'($urandom) : '0;
            if (($urandom % 3) == 0) begin
                int kind = int'($urandom % 5);
                wr_en = 1'b1;
                wr_data = $urandom;
                case (kind)
                    0: wr_addr = AW'($urandom % 2);
                    1: wr_addr = AW'(8'h08 + $urandom % 2);
                    2: wr_addr = AW'(8'h10 + $urandom % NCTX);
                    3: wr_addr = AW'(8'h18 + $urandom % NCTX);
                    default: wr_addr = AW'(8'h40 + $urandom % NSRC);
                endcase
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        cmp_hit = '0;
        step(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule